// File: doc/BRIEF.md
# Multiplexed-Bus Six-Port GPIO Controller

This block sits between a host that shares one set of lines for address and data and six byte-wide I/O ports: two that only drive, two that only sense, and two whose pins can be turned around bit by bit. The host first places an address on the shared lines while the latch-enable is high. It then either pulses the active-low write strobe with data on the lines, or pulses the active-low read strobe and expects the block to drive a value back.

All host signals are taken as already synchronized to the block clock. The block keeps the last address seen while the latch-enable was high, decodes an 8-bit address as a page number (upper five bits) and a register offset (lower three bits), and commits writes when the write strobe returns high. For reads it takes a snapshot of the selected value when the read strobe falls and holds it unchanged on the shared lines until the strobe rises. The host's shared lines are modelled as separate input, output and output-enable signals.

Top module: `muxbus_gpio`

## Requirements
- R1: While reset is high and on the cycle after it, both output ports, both configurable data registers and both direction registers read as zero (all configurable pins input), and `bus_oe` is 0.
- R2: The address is taken from `bus_in` on every clock edge that sees `ale` high and is held unchanged while `ale` is low, so data on `bus_in` after the latch phase does not change the target.
- R3: A write to offset 0 or 1 loads output port 0 or 1 with the value that was on `bus_in` in the last cycle `wr_n` was low; the port changes on the clock edge that first sees `wr_n` high again, and at no other time.
- R4: A write to offset 4 or 5 loads the data register of configurable port 0 or 1 (shown on `io0_out`/`io1_out`); a write to offset 6 or 7 loads its direction register (shown on `io0_dir`/`io1_dir`, bit value 1 = output).
- R5: Writes to offsets 2 and 3 (the input ports) change nothing, and writes whose address page (bits 7:3) differs from the parameter `PAGE` (default 4, so addresses 0x20 to 0x27) change nothing.
- R6: `bus_oe` goes high on the clock edge that first sees `rd_n` low with a matching page and drops on the edge that sees `rd_n` high; it never rises for a non-matching page.
- R7: A read returns: offsets 0/1 the output port value, 2/3 the input pins, 4/5 per bit the data register where the direction bit is 1 and the pin where it is 0, 6/7 the direction register.
- R8: The value on `bus_out` is captured when `rd_n` falls and stays stable for as long as `bus_oe` is high, even if the pins change meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable, high during the address phase |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Shared address/data lines as seen by the block |
| bus_out | output | 8 | Read data driven onto the shared lines |
| bus_oe | output | 1 | Enable of the tri-state read driver |
| out_p0 | output | 8 | Output-only port 0 |
| out_p1 | output | 8 | Output-only port 1 |
| in_p0 | input | 8 | Input-only port 0 pins |
| in_p1 | input | 8 | Input-only port 1 pins |
| io0_in | input | 8 | Configurable port 0 pin values |
| io0_out | output | 8 | Configurable port 0 drive value |
| io0_dir | output | 8 | Configurable port 0 per-bit direction, 1 = output |
| io1_in | input | 8 | Configurable port 1 pin values |
| io1_out | output | 8 | Configurable port 1 drive value |
| io1_dir | output | 8 | Configurable port 1 per-bit direction, 1 = output |

## Verification
Output ports are written with complementary patterns (0xA5 then 0x3C and 0x5C) so a swapped port select or a stuck bit shows up as a mismatch on the other port. Configurable ports are read with a half-output direction mask against pins that differ from the data register in every nibble, which tells the per-bit mix apart from reading only data or only pins. Writes to input offsets and to a foreign page, and reads of a foreign page, tell a full address decode from an offset-only one, and changing the input pins in the middle of a read separates a snapshot from a live path.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int OFS_W = 3;
    localparam int PG_W  = AW - OFS_W;
    localparam int NPORT = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_OUT0 = 3'd0,
        OFS_OUT1 = 3'd1,
        OFS_IN0  = 3'd2,
        OFS_IN1  = 3'd3,
        OFS_IO0  = 3'd4,
        OFS_IO1  = 3'd5,
        OFS_DIR0 = 3'd6,
        OFS_DIR1 = 3'd7
    } ofs_e;

    typedef struct packed {
        logic          hit;
        ofs_e          ofs;
        logic          wr_commit;
        logic          rd_start;
        logic          rd_active;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [DW-1:0] dat;
        logic [DW-1:0] dir;
    } cfg_port_t;

    function automatic logic [DW-1:0] pin_mix(input logic [DW-1:0] dat,
                                              input logic [DW-1:0] dir,
                                              input logic [DW-1:0] pins);
        return (dat & dir) | (pins & ~dir);
    endfunction

    function automatic logic ofs_writable(input ofs_e ofs);
        return !(ofs == OFS_IN0 || ofs == OFS_IN1);
    endfunction

endpackage

// File: rtl/gpb_front.sv
module gpb_front
    import gpb_pkg::*;
#(
    parameter logic [PG_W-1:0] PAGE = 5'd4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] bus_in,
    output bus_req_t      req
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          rd_q;
    logic          wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b1;
            wr_q    <= 1'b1;
        end else begin
            if (ale)
                addr_q <= bus_in;
            if (!wr_n)
                wdata_q <= bus_in[DW-1:0];
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    always_comb begin
        req.hit       = (addr_q[AW-1:OFS_W] == PAGE);
        req.ofs       = ofs_e'(addr_q[OFS_W-1:0]);
        req.wr_commit = wr_n && !wr_q;
        req.rd_start  = !rd_n && rd_q;
        req.rd_active = !rd_n;
        req.wdata     = wdata_q;
    end
endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
    import gpb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  bus_req_t                  req,
    output logic [NPORT-1:0][DW-1:0]  out_q,
    output cfg_port_t [NPORT-1:0]     cfg_q
);
    logic wr_ok;

    always_comb wr_ok = req.wr_commit && req.hit && ofs_writable(req.ofs);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam ofs_e OUT_SEL = ofs_e'(int'(OFS_OUT0) + g);
        localparam ofs_e DAT_SEL = ofs_e'(int'(OFS_IO0) + g);
        localparam ofs_e DIR_SEL = ofs_e'(int'(OFS_DIR0) + g);

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[g] <= '0;
                cfg_q[g] <= '0;
            end else if (wr_ok) begin
                if (req.ofs == OUT_SEL) out_q[g]     <= req.wdata;
                if (req.ofs == DAT_SEL) cfg_q[g].dat <= req.wdata;
                if (req.ofs == DIR_SEL) cfg_q[g].dir <= req.wdata;
            end
        end
    end
endmodule

// File: rtl/gpb_readpath.sv
module gpb_readpath
    import gpb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  bus_req_t                 req,
    input  logic [NPORT-1:0][DW-1:0] out_q,
    input  cfg_port_t [NPORT-1:0]    cfg_q,
    input  logic [NPORT-1:0][DW-1:0] in_pins,
    input  logic [NPORT-1:0][DW-1:0] io_pins,
    output logic [DW-1:0]            bus_out,
    output logic                     bus_oe
);
    logic [DW-1:0] sel_val;
    logic [DW-1:0] snap_q;
    logic          oe_q;

    always_comb begin
        unique case (req.ofs)
            OFS_OUT0: sel_val = out_q[0];
            OFS_OUT1: sel_val = out_q[1];
            OFS_IN0:  sel_val = in_pins[0];
            OFS_IN1:  sel_val = in_pins[1];
            OFS_IO0:  sel_val = pin_mix(cfg_q[0].dat, cfg_q[0].dir, io_pins[0]);
            OFS_IO1:  sel_val = pin_mix(cfg_q[1].dat, cfg_q[1].dir, io_pins[1]);
            OFS_DIR0: sel_val = cfg_q[0].dir;
            OFS_DIR1: sel_val = cfg_q[1].dir;
            default:  sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= req.rd_active && req.hit;
            if (req.rd_start)
                snap_q <= sel_val;
        end
    end

    assign bus_out = snap_q;
    assign bus_oe  = oe_q;
endmodule

// File: rtl/muxbus_gpio.sv
module muxbus_gpio
    import gpb_pkg::*;
#(
    parameter logic [PG_W-1:0] PAGE = 5'd4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic [DW-1:0] out_p0,
    output logic [DW-1:0] out_p1,
    input  logic [DW-1:0] in_p0,
    input  logic [DW-1:0] in_p1,
    input  logic [DW-1:0] io0_in,
    output logic [DW-1:0] io0_out,
    output logic [DW-1:0] io0_dir,
    input  logic [DW-1:0] io1_in,
    output logic [DW-1:0] io1_out,
    output logic [DW-1:0] io1_dir
);
    bus_req_t                 req;
    logic [NPORT-1:0][DW-1:0] out_q;
    cfg_port_t [NPORT-1:0]    cfg_q;
    logic [NPORT-1:0][DW-1:0] in_pins;
    logic [NPORT-1:0][DW-1:0] io_pins;
    logic                     addr_hit;

    assign in_pins  = {in_p1, in_p0};
    assign io_pins  = {io1_in, io0_in};
    assign addr_hit = req.hit;

    gpb_front #(.PAGE(PAGE)) u_front (
        .clk    (clk),
        .rst    (rst),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .bus_in (bus_in),
        .req    (req)
    );

    gpb_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .out_q (out_q),
        .cfg_q (cfg_q)
    );

    gpb_readpath u_rd (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .out_q   (out_q),
        .cfg_q   (cfg_q),
        .in_pins (in_pins),
        .io_pins (io_pins),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    assign out_p0  = out_q[0];
    assign out_p1  = out_q[1];
    assign io0_out = cfg_q[0].dat;
    assign io0_dir = cfg_q[0].dir;
    assign io1_out = cfg_q[1].dat;
    assign io1_dir = cfg_q[1].dir;
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_n,
    input logic       wr_n,
    input logic       bus_oe,
    input logic [7:0] bus_out,
    input logic [7:0] out_p0,
    input logic [7:0] out_p1,
    input logic [7:0] io0_dir,
    input logic [7:0] io1_dir,
    input logic       addr_hit
);
    // R1: reset leaves pins input and the read driver off
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (io0_dir == 8'h00 && io1_dir == 8'h00 && !bus_oe));

    // R3: output ports only move right after a write strobe rises
    p_out0_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_n && !$past(wr_n)) |=> $stable(out_p0));
    p_out1_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_n && !$past(wr_n)) |=> $stable(out_p1));

    // R6: driver on only after a low read strobe with a matching page
    p_oe_needs_rd_r6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ($past(!rd_n) && $past(addr_hit)));

    // R6: driver released once the strobe is seen high
    p_oe_release_r6: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> !bus_oe);

    // R8: driven data frozen for the whole read
    p_data_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out));
endmodule

bind muxbus_gpio gpb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bus_oe   (bus_oe),
    .bus_out  (bus_out),
    .out_p0   (out_p0),
    .out_p1   (out_p1),
    .io0_dir  (io0_dir),
    .io1_dir  (io1_dir),
    .addr_hit (addr_hit)
);

// File: tb/sim_muxbus_gpio.sv
module sim_muxbus_gpio;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] out_p0, out_p1;
    logic [7:0] in_p0 = 8'h00, in_p1 = 8'h00;
    logic [7:0] io0_in = 8'h00, io1_in = 8'h00;
    logic [7:0] io0_out, io0_dir, io1_out, io1_dir;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muxbus_gpio u0 (
        .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .out_p0(out_p0), .out_p1(out_p1), .in_p0(in_p0), .in_p1(in_p1),
        .io0_in(io0_in), .io0_out(io0_out), .io0_dir(io0_dir),
        .io1_in(io1_in), .io1_out(io1_out), .io1_dir(io1_dir)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
        ale = 1'b1; bus_in = addr;
        @(negedge clk);
        ale = 1'b0; bus_in = 8'hEE;
        @(negedge clk);
        wr_n = 1'b0; bus_in = data;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1; bus_in = 8'hEE;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] addr, output logic [7:0] data,
                            output logic oe, output logic oe_after);
        ale = 1'b1; bus_in = addr;
        @(negedge clk);
        ale = 1'b0; bus_in = 8'hEE;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        data = bus_out; oe = bus_oe;
        rd_n = 1'b1;
        @(negedge clk);
        oe_after = bus_oe;
    endtask

    task automatic t_reset;
        check("R1 out_p0", out_p0, 8'h00);
        check("R1 out_p1", out_p1, 8'h00);
        check("R1 io0_dir", io0_dir, 8'h00);
        check("R1 io1_dir", io1_dir, 8'h00);
        check("R1 io0_out", io0_out, 8'h00);
        check("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
    endtask

    task automatic t_out_ports;
        logic [7:0] d; logic oe, oe2;
        bus_write(8'h20, 8'hA5);
        check("R3 out_p0 loaded", out_p0, 8'hA5);
        check("R3 out_p1 untouched", out_p1, 8'h00);
        bus_write(8'h21, 8'h3C);
        check("R3 out_p1 loaded", out_p1, 8'h3C);
        bus_read(8'h20, d, oe, oe2);
        check("R7 read out0", d, 8'hA5);
        check("R6 oe during read", {7'b0, oe}, 8'h01);
        check("R6 oe released", {7'b0, oe2}, 8'h00);
    endtask

    task automatic t_write_timing;
        // R3: port holds old value until the strobe rises
        ale = 1'b1; bus_in = 8'h20;
        @(negedge clk);
        ale = 1'b0; wr_n = 1'b0; bus_in = 8'h11;
        @(negedge clk);
        bus_in = 8'h22;
        @(negedge clk);
        check("R3 no change while strobe low", out_p0, 8'hA5);
        wr_n = 1'b1; bus_in = 8'hEE;
        @(negedge clk);
        check("R3 last low-cycle data", out_p0, 8'h22);
    endtask

    task automatic t_addr_hold;
        // R2: the bus value during ale low (0xEE) must not retarget
        bus_write(8'h21, 8'h5C);
        check("R2 latched target", out_p1, 8'h5C);
        check("R2 other port kept", out_p0, 8'h22);
    endtask

    task automatic t_inputs;
        logic [7:0] d; logic oe, oe2;
        in_p0 = 8'hC3; in_p1 = 8'h96;
        bus_read(8'h22, d, oe, oe2);
        check("R7 read in0", d, 8'hC3);
        bus_read(8'h23, d, oe, oe2);
        check("R7 read in1", d, 8'h96);
    endtask

    task automatic t_config;
        logic [7:0] d; logic oe, oe2;
        bus_write(8'h26, 8'hF0);
        check("R4 dir0", io0_dir, 8'hF0);
        bus_write(8'h24, 8'h0F);
        check("R4 io0 data", io0_out, 8'h0F);
        io0_in = 8'h5A;
        bus_read(8'h24, d, oe, oe2);
        check("R7 io0 mixed", d, 8'h0A);
        bus_write(8'h27, 8'hFF);
        bus_write(8'h25, 8'h69);
        check("R4 io1 dir", io1_dir, 8'hFF);
        check("R4 io1 data", io1_out, 8'h69);
        io1_in = 8'h00;
        bus_read(8'h25, d, oe, oe2);
        check("R7 io1 all out", d, 8'h69);
        bus_read(8'h26, d, oe, oe2);
        check("R7 read dir0", d, 8'hF0);
    endtask

    task automatic t_ignored;
        logic [7:0] d; logic oe, oe2;
        bus_write(8'h22, 8'h77);
        bus_write(8'h23, 8'h77);
        check("R5 in-offset out0", out_p0, 8'h22);
        check("R5 in-offset out1", out_p1, 8'h5C);
        check("R5 in-offset io0", io0_out, 8'h0F);
        check("R5 in-offset dir0", io0_dir, 8'hF0);
        bus_read(8'h22, d, oe, oe2);
        check("R5 in0 still pins", d, 8'hC3);
        bus_write(8'h40, 8'h99);
        check("R5 foreign page out0", out_p0, 8'h22);
        bus_write(8'h06, 8'h00);
        check("R5 foreign page dir0", io0_dir, 8'hF0);
        bus_read(8'h41, d, oe, oe2);
        check("R6 no oe foreign page", {7'b0, oe}, 8'h00);
    endtask

    task automatic t_freeze;
        in_p0 = 8'h81;
        ale = 1'b1; bus_in = 8'h22;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        check("R8 first value", bus_out, 8'h81);
        in_p0 = 8'h18;
        @(negedge clk);
        @(negedge clk);
        check("R8 held after pin change", bus_out, 8'h81);
        check("R6 oe held", {7'b0, bus_oe}, 8'h01);
        rd_n = 1'b1;
        @(negedge clk);
        check("R6 oe dropped", {7'b0, bus_oe}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_out_ports();
        t_write_timing();
        t_addr_hold();
        t_inputs();
        t_config();
        t_ignored();
        t_freeze();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule